// File: doc/BRIEF.md
# Effective Address Quadrant Decoder

This block sits at the front of a two-level address translation unit. For every request it takes a 64-bit effective address, the privilege mode of the access (hypervisor or guest), the access kind, and the current partition-ID and process-ID register contents. From these it resolves the effective partition and process identifiers that the later table walk will use. The two most significant address bits choose one of four quadrants. Hypervisor mode and guest mode map the quadrants to identifiers differently.

Some addresses cannot be translated. These are addresses with any bit set in the reserved gap just below the quadrant field, and guest addresses in the two middle quadrants. For these the block does not produce identifiers. It reports a segment fault instead. The fault is classed as an instruction fault or a data fault from the access kind, and a data fault also captures the faulting address. The block accepts one request per `req_valid` cycle and answers exactly one cycle later. A single-cycle `rsp_done` pulse marks the answer, and the result is held until the next request.

Top module: `eaq_resolver`

## Requirements
- R1: A synchronous active-high `rst` drives every output to zero at the next rising edge: `rsp_done`, `rsp_fault`, `rsp_kind`, `rsp_code`, `rsp_fault_addr`, `rsp_part` and `rsp_proc`.
- R2: A request sampled with `req_valid` high produces `rsp_done` high in the following cycle only. While `req_valid` is low, every result output keeps its value.
- R3: If any of address bits 61 down to 52 is set, the request faults, in either mode and in any quadrant.
- R4: In hypervisor mode (`req_hyp`=1), with address bits 63:62 as the quadrant: quadrant 0 gives partition 0 and the process register. Quadrant 1 gives both registers. Quadrant 2 gives the partition register and process 0. Quadrant 3 gives 0 for both.
- R5: In guest mode (`req_hyp`=0), quadrant 0 gives the partition register and the process register. Quadrant 3 gives the partition register and process 0.
- R6: In guest mode, quadrants 1 and 2 fault.
- R7: The access kind is encoded as 00 load, 01 store, 10 fetch and 11 other data. A faulting fetch sets `rsp_kind`=10 (instruction segment) and `rsp_fault_addr`=0. A faulting data access sets `rsp_kind`=01 (data segment) and `rsp_fault_addr` to the request address. A result without a fault has `rsp_kind`=00 and `rsp_fault_addr`=0.
- R8: A faulting result has `rsp_code`=0, `rsp_part`=0 and `rsp_proc`=0. `rsp_code` is zero for every result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Effective address |
| req_hyp | input | 1 | 1 = hypervisor mode, 0 = guest mode |
| req_access | input | 2 | Access kind (00 load, 01 store, 10 fetch, 11 other data) |
| part_reg | input | 12 | Current partition-ID register |
| proc_reg | input | 20 | Current process-ID register |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Segment fault raised |
| rsp_kind | output | 2 | 00 none, 01 data segment, 10 instruction segment |
| rsp_code | output | 8 | Error code sent with the result |
| rsp_fault_addr | output | 64 | Captured address of a data segment fault |
| rsp_part | output | 12 | Resolved partition ID |
| rsp_proc | output | 20 | Resolved process ID |

## Verification
The assertions check the following on every cycle:
- the done pulse follows a request and nothing else;
- the results hold between requests;
- a reserved-gap hit or an illegal guest quadrant always ends in a fault;
- a fault carries zero identifiers and a zero code;
- the fault class agrees with the fault flag;
- a hypervisor quadrant 3 request yields zeros.

Only the bench scenarios show some behaviours. These are the exact identifier selection in each of the eight mode and quadrant pairs, the captured data address against the request, and the split between fetch and data classes for each access encoding. The scenarios also cover outputs that stay held while the register inputs change, and a reset that arrives after a fault.

// File: rtl/eaq_pkg.sv
package eaq_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_OTHER = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    SEG_NONE  = 2'b00,
    SEG_DATA  = 2'b01,
    SEG_INSTR = 2'b10
  } seg_e;

  localparam logic [1:0] QUAD_0 = 2'd0;
  localparam logic [1:0] QUAD_1 = 2'd1;
  localparam logic [1:0] QUAD_2 = 2'd2;
  localparam logic [1:0] QUAD_3 = 2'd3;

endpackage

// File: rtl/eaq_range_check.sv
module eaq_range_check #(
  parameter int ADDR_W = 64,
  parameter int GAP_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              bad
);
  localparam int GAP_HI = ADDR_W - 3;
  localparam int GAP_LO = GAP_HI - GAP_W + 1;

  function automatic logic gap_hit(input logic [GAP_W-1:0] field);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < GAP_W; i++) hit = hit | field[i];
    return hit;
  endfunction

  assign bad = gap_hit(addr[GAP_HI:GAP_LO]);
endmodule

// File: rtl/eaq_id_select.sv
module eaq_id_select
  import eaq_pkg::*;
#(
  parameter int PART_W = 12,
  parameter int PROC_W = 20
) (
  input  logic [1:0]        quad,
  input  logic              hyp,
  input  logic [PART_W-1:0] part_in,
  input  logic [PROC_W-1:0] proc_in,
  output logic [PART_W-1:0] part_out,
  output logic [PROC_W-1:0] proc_out,
  output logic              illegal
);
  // per quadrant: {use partition register, use process register, legal}
  function automatic logic [2:0] quad_map(input logic h, input logic [1:0] q);
    logic [2:0] m;
    if (h) begin
      case (q)
        QUAD_0:  m = 3'b011;
        QUAD_1:  m = 3'b111;
        QUAD_2:  m = 3'b101;
        default: m = 3'b001;
      endcase
    end else begin
      case (q)
        QUAD_0:  m = 3'b111;
        QUAD_3:  m = 3'b101;
        default: m = 3'b000;
      endcase
    end
    return m;
  endfunction

  logic [2:0] sel;
  assign sel      = quad_map(hyp, quad);
  assign part_out = sel[2] ? part_in : '0;
  assign proc_out = sel[1] ? proc_in : '0;
  assign illegal  = ~sel[0];
endmodule

// File: rtl/eaq_fault_encode.sv
module eaq_fault_encode
  import eaq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int ERR_W  = 8
) (
  input  logic              seg_fault,
  input  logic [1:0]        access,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        kind,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [ERR_W-1:0]  code
);
  function automatic logic [1:0] classify(input logic f, input logic [1:0] a);
    if (!f)                 return SEG_NONE;
    else if (a == ACC_FETCH) return SEG_INSTR;
    else                    return SEG_DATA;
  endfunction

  assign kind       = classify(seg_fault, access);
  assign fault_addr = (kind == SEG_DATA) ? addr : '0;
  assign code       = '0;
endmodule

// File: rtl/eaq_resolver.sv
module eaq_resolver
  import eaq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int GAP_W  = 10,
  parameter int PART_W = 12,
  parameter int PROC_W = 20,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_hyp,
  input  logic [1:0]        req_access,
  input  logic [PART_W-1:0] part_reg,
  input  logic [PROC_W-1:0] proc_reg,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [1:0]        rsp_kind,
  output logic [ERR_W-1:0]  rsp_code,
  output logic [ADDR_W-1:0] rsp_fault_addr,
  output logic [PART_W-1:0] rsp_part,
  output logic [PROC_W-1:0] rsp_proc
);
  localparam int QUAD_HI = ADDR_W - 1;

  logic              range_bad;
  logic              quad_illegal;
  logic              seg_fault;
  logic [PART_W-1:0] sel_part;
  logic [PROC_W-1:0] sel_proc;
  logic [1:0]        nxt_kind;
  logic [ADDR_W-1:0] nxt_faddr;
  logic [ERR_W-1:0]  nxt_code;

  eaq_range_check #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_range (
    .addr (req_addr),
    .bad  (range_bad)
  );

  eaq_id_select #(.PART_W(PART_W), .PROC_W(PROC_W)) u_sel (
    .quad     (req_addr[QUAD_HI -: 2]),
    .hyp      (req_hyp),
    .part_in  (part_reg),
    .proc_in  (proc_reg),
    .part_out (sel_part),
    .proc_out (sel_proc),
    .illegal  (quad_illegal)
  );

  assign seg_fault = range_bad | quad_illegal;

  eaq_fault_encode #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_enc (
    .seg_fault  (seg_fault),
    .access     (req_access),
    .addr       (req_addr),
    .kind       (nxt_kind),
    .fault_addr (nxt_faddr),
    .code       (nxt_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done       <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_kind       <= SEG_NONE;
      rsp_code       <= '0;
      rsp_fault_addr <= '0;
      rsp_part       <= '0;
      rsp_proc       <= '0;
    end else begin
      rsp_done <= req_valid;
      if (req_valid) begin
        rsp_fault      <= seg_fault;
        rsp_kind       <= nxt_kind;
        rsp_code       <= nxt_code;
        rsp_fault_addr <= nxt_faddr;
        rsp_part       <= seg_fault ? '0 : sel_part;
        rsp_proc       <= seg_fault ? '0 : sel_proc;
      end
    end
  end
endmodule

// File: rtl/eaq_checker.sv
module eaq_checker #(
  parameter int ADDR_W = 64,
  parameter int PART_W = 12,
  parameter int PROC_W = 20,
  parameter int ERR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_hyp,
  input logic              rsp_done,
  input logic              rsp_fault,
  input logic [1:0]        rsp_kind,
  input logic [ERR_W-1:0]  rsp_code,
  input logic [ADDR_W-1:0] rsp_fault_addr,
  input logic [PART_W-1:0] rsp_part,
  input logic [PROC_W-1:0] rsp_proc,
  input logic              range_bad,
  input logic              quad_illegal,
  input logic              seg_fault
);
  logic [1:0] quad;
  assign quad = req_addr[ADDR_W-1 -: 2];

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!rsp_done && !rsp_fault && rsp_kind == 2'b00));

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_done);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_done);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_part) && $stable(rsp_proc) &&
                    $stable(rsp_fault) && $stable(rsp_fault_addr)));

  assert_gap_fault_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && range_bad) |=> rsp_fault);

  assert_fault_source_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_fault == $past(seg_fault)));

  assert_hyp_q3_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_hyp && !range_bad && quad == 2'd3)
      |=> (!rsp_fault && rsp_part == '0 && rsp_proc == '0));

  assert_guest_illegal_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_hyp && (quad == 2'd1 || quad == 2'd2))
      |=> (rsp_fault && $past(quad_illegal)));

  assert_kind_flag_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_fault == (rsp_kind != 2'b00));

  assert_instr_no_addr_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_kind == 2'b10) |-> (rsp_fault_addr == '0));

  assert_fault_zero_ids_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_part == '0 && rsp_proc == '0 && rsp_code == '0));
endmodule

bind eaq_resolver eaq_checker #(
  .ADDR_W(ADDR_W), .PART_W(PART_W), .PROC_W(PROC_W), .ERR_W(ERR_W)
) u_eaq_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_addr       (req_addr),
  .req_hyp        (req_hyp),
  .rsp_done       (rsp_done),
  .rsp_fault      (rsp_fault),
  .rsp_kind       (rsp_kind),
  .rsp_code       (rsp_code),
  .rsp_fault_addr (rsp_fault_addr),
  .rsp_part       (rsp_part),
  .rsp_proc       (rsp_proc),
  .range_bad      (range_bad),
  .quad_illegal   (quad_illegal),
  .seg_fault      (seg_fault)
);

// File: tb/test_eaq_resolver.sv
`timescale 1ns/1ps
module test_eaq_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        req_hyp = 1'b0;
  logic [1:0]  req_access = 2'b00;
  logic [11:0] part_reg = '0;
  logic [19:0] proc_reg = '0;
  logic        rsp_done, rsp_fault;
  logic [1:0]  rsp_kind;
  logic [7:0]  rsp_code;
  logic [63:0] rsp_fault_addr;
  logic [11:0] rsp_part;
  logic [19:0] rsp_proc;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  eaq_resolver i_eaq_resolver (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_hyp(req_hyp), .req_access(req_access), .part_reg(part_reg),
    .proc_reg(proc_reg), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_kind(rsp_kind), .rsp_code(rsp_code), .rsp_fault_addr(rsp_fault_addr),
    .rsp_part(rsp_part), .rsp_proc(rsp_proc)
  );

  // {addr, hyp, access, exp_fault, exp_kind, part_from_reg, proc_from_reg}
  typedef struct packed {
    logic [63:0] addr;
    logic        hyp;
    logic [1:0]  acc;
    logic        fault;
    logic [1:0]  kind;
    logic        use_part;
    logic        use_proc;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{64'h0000_0000_0000_1000, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 1'b1}, // R4 q0
    '{64'h4000_0000_0000_2000, 1'b1, 2'b01, 1'b0, 2'b00, 1'b1, 1'b1}, // R4 q1
    '{64'h8000_0000_00AB_C000, 1'b1, 2'b10, 1'b0, 2'b00, 1'b1, 1'b0}, // R4 q2
    '{64'hC000_0000_0000_0000, 1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0}, // R4 q3
    '{64'h0000_0000_0001_0000, 1'b0, 2'b10, 1'b0, 2'b00, 1'b1, 1'b1}, // R5 q0
    '{64'hC00F_FFFF_FFFF_FFFF, 1'b0, 2'b01, 1'b0, 2'b00, 1'b1, 1'b0}, // R5 q3
    '{64'h4000_0000_0000_0000, 1'b0, 2'b00, 1'b1, 2'b01, 1'b0, 1'b0}, // R6 q1 load
    '{64'h8000_0000_0000_4000, 1'b0, 2'b10, 1'b1, 2'b10, 1'b0, 1'b0}, // R6 q2 fetch
    '{64'h0010_0000_0000_0000, 1'b1, 2'b01, 1'b1, 2'b01, 1'b0, 1'b0}, // R3 bit52
    '{64'hE000_0000_0000_0000, 1'b1, 2'b10, 1'b1, 2'b10, 1'b0, 1'b0}, // R3 bit61
    '{64'h0200_0000_0000_0040, 1'b0, 2'b11, 1'b1, 2'b01, 1'b0, 1'b0}, // R3/R7 other
    '{64'h4000_0000_0000_0008, 1'b0, 2'b01, 1'b1, 2'b01, 1'b0, 1'b0}, // R6 q1 store
    '{64'h800F_FFFF_FFFF_FFFF, 1'b1, 2'b11, 1'b0, 2'b00, 1'b1, 1'b0}  // R4 q2 low bits
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] a, input logic h, input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_hyp = h; req_access = acc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    part_reg = 12'hA5C;
    proc_reg = 20'h3C0DE;
    repeat (3) @(negedge clk);
    check("R1", "done after reset", 64'(rsp_done), 64'd0);
    check("R1", "fault after reset", 64'(rsp_fault), 64'd0);
    check("R1", "part after reset", 64'(rsp_part), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [63:0] ef;
      issue(VEC[i].addr, VEC[i].hyp, VEC[i].acc);
      ef = (VEC[i].kind == 2'b01) ? VEC[i].addr : 64'd0;
      check("R2", $sformatf("done v%0d", i), 64'(rsp_done), 64'd1);
      check("R3/R6", $sformatf("fault v%0d", i), 64'(rsp_fault), 64'(VEC[i].fault));
      check("R7", $sformatf("kind v%0d", i), 64'(rsp_kind), 64'(VEC[i].kind));
      check("R7", $sformatf("faddr v%0d", i), rsp_fault_addr, ef);
      check("R4/R5", $sformatf("part v%0d", i), 64'(rsp_part),
            VEC[i].use_part ? 64'(part_reg) : 64'd0);
      check("R4/R5", $sformatf("proc v%0d", i), 64'(rsp_proc),
            VEC[i].use_proc ? 64'(proc_reg) : 64'd0);
      check("R8", $sformatf("code v%0d", i), 64'(rsp_code), 64'd0);
    end

    // R2: pulse drops and result holds while inputs change without req_valid
    issue(64'h4000_0000_0000_0000, 1'b1, 2'b00);
    part_reg = 12'h123; proc_reg = 20'h45678;
    req_addr = 64'h4000_0000_0000_0000; req_hyp = 1'b0;
    @(negedge clk);
    check("R2", "done drops", 64'(rsp_done), 64'd0);
    check("R2", "part held", 64'(rsp_part), 64'hA5C);
    check("R2", "proc held", 64'(rsp_proc), 64'h3C0DE);
    check("R2", "no fault while idle", 64'(rsp_fault), 64'd0);

    // R4: back-to-back requests, new register values
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h0; req_hyp = 1'b1; req_access = 2'b00;
    @(negedge clk);
    check("R4", "b2b q0 part", 64'(rsp_part), 64'd0);
    check("R4", "b2b q0 proc", 64'(rsp_proc), 64'h45678);
    req_addr = 64'h4000_0000_0000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "b2b done", 64'(rsp_done), 64'd1);
    check("R4", "b2b q1 part", 64'(rsp_part), 64'h123);

    // R3: every gap bit alone faults
    for (int b = 52; b <= 61; b++) begin
      issue(64'd1 << b, 1'b1, 2'b01);
      check("R3", $sformatf("gap bit %0d", b), 64'(rsp_fault), 64'd1);
    end

    // R1: reset after a fault clears outputs
    issue(64'h8000_0000_0000_0010, 1'b0, 2'b00);
    check("R7", "faddr before reset", rsp_fault_addr, 64'h8000_0000_0000_0010);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "fault cleared", 64'(rsp_fault), 64'd0);
    check("R1", "kind cleared", 64'(rsp_kind), 64'd0);
    check("R1", "faddr cleared", rsp_fault_addr, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule